// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the hardware steps a processor takes when it enters an exception handler. The core may run a 32-bit instruction set or a compact 16-bit instruction set. While the sequencer is idle it watches a vector of pending exception requests. If any request is raised, it picks the most urgent one and captures the current status word and the address of the interrupted instruction. It then issues five writes, one per cycle, in a fixed order:

- the saved status register of the target mode;
- the status register with the compact-state bit cleared;
- the status register with the new mode and interrupt masks;
- the link register of the target mode;
- the program counter, loaded with the vector address.

The link value depends on both the exception kind and the instruction state the core was in. This lets a handler use one return sequence whatever state it interrupted. The same vector table serves both states.

The state machine has six named states:

- `ST_IDLE`: waiting for a request.
- `ST_SAVE`: saved-status write.
- `ST_STATE`: compact-state bit cleared.
- `ST_MODE`: mode and masks written.
- `ST_LINK`: link write.
- `ST_VECTOR`: PC write and done pulse.

The transitions are:

- ACCEPT: `ST_IDLE` to `ST_SAVE` when any request bit is set.
- STEP: each write state moves to the next one unconditionally.
- FINISH: `ST_VECTOR` to `ST_IDLE`.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is asserted, and in the cycles after it until a request arrives, busy, done and all four write strobes are low.
- R2: Request bits are [0] reset, [1] undefined instruction, [2] software interrupt, [3] prefetch abort, [4] data abort, [5] IRQ, [6] FIQ. When the block is idle and any bit is set at a clock edge, busy is high in the next cycle, and the five write steps follow in five consecutive cycles.
- R3: When several bits are set, the exception taken is the first set bit in the order reset, data abort, FIQ, IRQ, prefetch abort, undefined instruction, software interrupt.
- R4: In the first busy cycle only the saved-status strobe is high. Its data equals the status word captured at acceptance. bank_mode gives the target mode: 10011 for reset and software interrupt, 11011 for undefined instruction, 10111 for either abort, 10010 for IRQ, 10001 for FIQ.
- R5: In the second cycle the status strobe is high, with data equal to the captured status word with bit 5 (compact-state bit) cleared and every other bit unchanged.
- R6: In the third cycle the status strobe is high. Bits [4:0] hold the target mode, bit 5 is 0 and bit 7 (IRQ mask) is 1. Bit 6 (FIQ mask) is 1 for reset and FIQ and is kept otherwise. Bits above 7 are kept.
- R7: In the fourth cycle the link strobe is high. The link value is computed from the captured instruction address A. It is A+4 for IRQ, FIQ and prefetch abort, and A+8 for data abort. For undefined instruction and software interrupt it is A+4 in 32-bit state and A+2 in 16-bit state. For reset it is 0. All sums wrap modulo 2^32.
- R8: In the fifth cycle the PC strobe and done are high together. The PC value is VEC_BASE plus 4 times the kind code: reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, IRQ 6, FIQ 7. In the following cycle done and busy are low.
- R9: While busy, changes on the requests, status word and address inputs have no effect on the sequence in progress. No new sequence starts before the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 7 | Pending exception requests |
| cur_psr | input | XLEN | Current status word |
| cur_pc | input | XLEN | Address of the interrupted instruction |
| spsr_we | output | 1 | Saved-status write strobe |
| spsr_wdata | output | XLEN | Saved-status write data |
| bank_mode | output | 5 | Target mode selecting the banked registers |
| psr_we | output | 1 | Status write strobe |
| psr_wdata | output | XLEN | Status write data |
| lr_we | output | 1 | Link write strobe |
| lr_wdata | output | XLEN | Link write data |
| pc_we | output | 1 | PC write strobe |
| pc_wdata | output | XLEN | Vector address |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequence in progress |

## Verification
The bench builds the block with XLEN at 32 and VEC_BASE at 0xFFFF0000. The non-zero base shows that the vector offset is added and not simply substituted. With only seven request lines, every one of the 127 request combinations is driven, along with every exception kind in both instruction states. The instruction addresses chosen include one whose link sum wraps past the top of the address space. Each run also toggles all inputs while the sequence is busy, to show they are ignored.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int NUM_REQ = 7;
    localparam int MODE_W  = 5;
    localparam int PSR_T   = 5;
    localparam int PSR_F   = 6;
    localparam int PSR_I   = 7;

    localparam int RQ_RESET = 0;
    localparam int RQ_UNDEF = 1;
    localparam int RQ_SWI   = 2;
    localparam int RQ_PABT  = 3;
    localparam int RQ_DABT  = 4;
    localparam int RQ_IRQ   = 5;
    localparam int RQ_FIQ   = 6;

    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;

    // Kind code equals the vector slot index
    typedef enum logic [2:0] {
        EK_RESET = 3'd0,
        EK_UNDEF = 3'd1,
        EK_SWI   = 3'd2,
        EK_PABT  = 3'd3,
        EK_DABT  = 3'd4,
        EK_IRQ   = 3'd6,
        EK_FIQ   = 3'd7
    } exc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE,
        ST_STATE,
        ST_MODE,
        ST_LINK,
        ST_VECTOR
    } seq_state_e;
endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick
    import exc_entry_pkg::*;
(
    input  logic [NUM_REQ-1:0] req,
    output logic               valid,
    output exc_kind_e          kind
);
    always_comb begin
        valid = |req;
        if (req[RQ_RESET])     kind = EK_RESET;
        else if (req[RQ_DABT]) kind = EK_DABT;
        else if (req[RQ_FIQ])  kind = EK_FIQ;
        else if (req[RQ_IRQ])  kind = EK_IRQ;
        else if (req[RQ_PABT]) kind = EK_PABT;
        else if (req[RQ_UNDEF]) kind = EK_UNDEF;
        else                   kind = EK_SWI;
    end
endmodule

// File: rtl/exc_link_calc.sv
module exc_link_calc
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  exc_kind_e        kind,
    input  logic             compact,
    input  logic [XLEN-1:0]  addr,
    output logic [XLEN-1:0]  link
);
    localparam logic [XLEN-1:0] STEP_HALF = XLEN'(2);
    localparam logic [XLEN-1:0] STEP_WORD = XLEN'(4);
    localparam logic [XLEN-1:0] STEP_DBL  = XLEN'(8);

    always_comb begin
        unique case (kind)
            EK_RESET:        link = '0;
            EK_UNDEF, EK_SWI: link = addr + (compact ? STEP_HALF : STEP_WORD);
            EK_DABT:         link = addr + STEP_DBL;
            EK_PABT, EK_IRQ, EK_FIQ: link = addr + STEP_WORD;
            default:         link = '0;
        endcase
    end
endmodule

// File: rtl/exc_target_map.sv
module exc_target_map
    import exc_entry_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input  exc_kind_e          kind,
    output logic [XLEN-1:0]    vector,
    output logic [MODE_W-1:0]  mode,
    output logic               mask_fiq
);
    logic [4:0] slot_off;

    always_comb begin
        slot_off = {kind, 2'b00};
        vector   = VEC_BASE + XLEN'(slot_off);
        mask_fiq = (kind == EK_RESET) || (kind == EK_FIQ);
        unique case (kind)
            EK_RESET, EK_SWI:  mode = MODE_SVC;
            EK_UNDEF:          mode = MODE_UND;
            EK_PABT, EK_DABT:  mode = MODE_ABT;
            EK_IRQ:            mode = MODE_IRQ;
            EK_FIQ:            mode = MODE_FIQ;
            default:           mode = MODE_SVC;
        endcase
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] exc_req,
    input  logic [XLEN-1:0]    cur_psr,
    input  logic [XLEN-1:0]    cur_pc,
    output logic               spsr_we,
    output logic [XLEN-1:0]    spsr_wdata,
    output logic [MODE_W-1:0]  bank_mode,
    output logic               psr_we,
    output logic [XLEN-1:0]    psr_wdata,
    output logic               lr_we,
    output logic [XLEN-1:0]    lr_wdata,
    output logic               pc_we,
    output logic [XLEN-1:0]    pc_wdata,
    output logic               done,
    output logic               busy
);
    seq_state_e        state, state_nx;
    exc_kind_e         kind_q, pick_kind;
    logic              pick_valid;
    logic [XLEN-1:0]   psr_q, pc_q;
    logic [XLEN-1:0]   link_val, vec_val;
    logic [MODE_W-1:0] tgt_mode;
    logic              tgt_mask_f;

    exc_prio_pick u_pick (
        .req   (exc_req),
        .valid (pick_valid),
        .kind  (pick_kind)
    );

    exc_link_calc #(.XLEN(XLEN)) u_link (
        .kind    (kind_q),
        .compact (psr_q[PSR_T]),
        .addr    (pc_q),
        .link    (link_val)
    );

    exc_target_map #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_map (
        .kind     (kind_q),
        .vector   (vec_val),
        .mode     (tgt_mode),
        .mask_fiq (tgt_mask_f)
    );

    // Next-state logic
    always_comb begin
        unique case (state)
            ST_IDLE:   state_nx = pick_valid ? ST_SAVE : ST_IDLE;
            ST_SAVE:   state_nx = ST_STATE;
            ST_STATE:  state_nx = ST_MODE;
            ST_MODE:   state_nx = ST_LINK;
            ST_LINK:   state_nx = ST_VECTOR;
            ST_VECTOR: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register and capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            kind_q <= EK_RESET;
            psr_q  <= '0;
            pc_q   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && pick_valid) begin
                kind_q <= pick_kind;
                psr_q  <= cur_psr;
                pc_q   <= cur_pc;
            end
        end
    end

    // Outputs
    always_comb begin
        spsr_we    = 1'b0;
        psr_we     = 1'b0;
        lr_we      = 1'b0;
        pc_we      = 1'b0;
        done       = 1'b0;
        busy       = (state != ST_IDLE);
        spsr_wdata = psr_q;
        bank_mode  = tgt_mode;
        psr_wdata  = psr_q;
        lr_wdata   = link_val;
        pc_wdata   = vec_val;
        unique case (state)
            ST_IDLE: ;
            ST_SAVE: spsr_we = 1'b1;
            ST_STATE: begin
                psr_we           = 1'b1;
                psr_wdata[PSR_T] = 1'b0;
            end
            ST_MODE: begin
                psr_we                = 1'b1;
                psr_wdata[MODE_W-1:0] = tgt_mode;
                psr_wdata[PSR_T]      = 1'b0;
                psr_wdata[PSR_F]      = psr_q[PSR_F] | tgt_mask_f;
                psr_wdata[PSR_I]      = 1'b1;
            end
            ST_LINK: lr_we = 1'b1;
            ST_VECTOR: begin
                pc_we = 1'b1;
                done  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [XLEN-1:0]   cur_psr,
    input logic              busy,
    input logic              spsr_we,
    input logic [XLEN-1:0]   spsr_wdata,
    input logic              psr_we,
    input logic [XLEN-1:0]   psr_wdata,
    input logic [MODE_W-1:0] bank_mode,
    input logic              lr_we,
    input logic              pc_we,
    input logic [XLEN-1:0]   pc_wdata,
    input logic              done
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(spsr_we || psr_we || lr_we || pc_we || done));

    assert_save_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (spsr_we && spsr_wdata == $past(cur_psr)));

    assert_state_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spsr_we |=> (psr_we && !psr_wdata[PSR_T]
                     && (psr_wdata | (XLEN'(1) << PSR_T)) == ($past(spsr_wdata) | (XLEN'(1) << PSR_T))));

    assert_mode_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (psr_we && $past(psr_we)) |-> (psr_wdata[MODE_W-1:0] == bank_mode && psr_wdata[PSR_I]));

    assert_link_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (psr_we && $past(psr_we)) |=> lr_we);

    assert_vector_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |=> (pc_we && done && pc_wdata[1:0] == 2'b00));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_one_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({spsr_we, psr_we, lr_we, pc_we}));
endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_psr    (cur_psr),
    .busy       (busy),
    .spsr_we    (spsr_we),
    .spsr_wdata (spsr_wdata),
    .psr_we     (psr_we),
    .psr_wdata  (psr_wdata),
    .bank_mode  (bank_mode),
    .lr_we      (lr_we),
    .pc_we      (pc_we),
    .pc_wdata   (pc_wdata),
    .done       (done)
);

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
    localparam logic [31:0] BASE = 32'hFFFF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  exc_req = '0;
    logic [31:0] cur_psr = '0;
    logic [31:0] cur_pc = '0;
    logic        spsr_we, psr_we, lr_we, pc_we, done, busy;
    logic [31:0] spsr_wdata, psr_wdata, lr_wdata, pc_wdata;
    logic [4:0]  bank_mode;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    exc_entry_seq #(.XLEN(32), .VEC_BASE(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .cur_psr(cur_psr), .cur_pc(cur_pc),
        .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .bank_mode(bank_mode),
        .psr_we(psr_we), .psr_wdata(psr_wdata), .lr_we(lr_we), .lr_wdata(lr_wdata),
        .pc_we(pc_we), .pc_wdata(pc_wdata), .done(done), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Request index of the winner (R3 order)
    function automatic int win_idx(input logic [6:0] r);
        int ord[7] = '{0, 4, 6, 5, 3, 1, 2};
        for (int k = 0; k < 7; k++)
            if (r[ord[k]]) return ord[k];
        return -1;
    endfunction

    function automatic logic [4:0] exp_mode(input int idx);
        case (idx)
            0, 2:    return 5'b10011;
            1:       return 5'b11011;
            3, 4:    return 5'b10111;
            5:       return 5'b10010;
            default: return 5'b10001;
        endcase
    endfunction

    function automatic logic [31:0] exp_link(input int idx, input bit t, input logic [31:0] a);
        case (idx)
            0:       return 32'h0;
            1, 2:    return t ? a + 32'd2 : a + 32'd4;
            4:       return a + 32'd8;
            default: return a + 32'd4;
        endcase
    endfunction

    function automatic logic [31:0] exp_vec(input int idx);
        int code;
        code = (idx >= 5) ? idx + 1 : idx;
        return BASE + 32'(code * 4);
    endfunction

    task automatic run_entry(input logic [6:0] req, input logic [31:0] psr,
                             input logic [31:0] pc, input logic [6:0] noise);
        int idx;
        logic [31:0] p3;
        idx = win_idx(req);
        p3 = (psr & ~32'h3F) | 32'(exp_mode(idx)) | 32'h80
             | (((idx == 0) || (idx == 6)) ? 32'h40 : 32'h0);
        @(negedge clk);
        exc_req = req; cur_psr = psr; cur_pc = pc;
        @(negedge clk);
        exc_req = noise; cur_psr = ~psr; cur_pc = ~pc;
        chk(busy === 1'b1, "R2 busy after accept", 32'(busy), 32'h1);
        chk(spsr_we === 1'b1 && !psr_we && !lr_we && !pc_we && spsr_wdata === psr,
            "R4 saved status", spsr_wdata, psr);
        chk(bank_mode === exp_mode(idx), "R3/R4 target mode", 32'(bank_mode), 32'(exp_mode(idx)));
        @(negedge clk);
        chk(psr_we === 1'b1 && !spsr_we && psr_wdata === (psr & ~32'h20),
            "R5 compact bit cleared", psr_wdata, psr & ~32'h20);
        @(negedge clk);
        chk(psr_we === 1'b1 && psr_wdata === p3, "R6 mode and masks", psr_wdata, p3);
        @(negedge clk);
        chk(lr_we === 1'b1 && !psr_we && lr_wdata === exp_link(idx, psr[5], pc),
            "R7 link value", lr_wdata, exp_link(idx, psr[5], pc));
        @(negedge clk);
        chk(pc_we === 1'b1 && done === 1'b1 && pc_wdata === exp_vec(idx),
            "R8/R9 vector", pc_wdata, exp_vec(idx));
        exc_req = '0;
        @(negedge clk);
        chk(!busy && !done && !pc_we && !spsr_we, "R8/R9 idle after done",
            32'({busy, done, pc_we, spsr_we}), 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] pcs[3] = '{32'h0000_1000, 32'h8000_0FFC, 32'hFFFF_FFFC};
        logic [31:0] psrs[2] = '{32'h6000_0013, 32'hF000_00D0};
        repeat (3) @(negedge clk);
        chk(!busy && !done && !spsr_we && !psr_we && !lr_we && !pc_we,
            "R1 quiet in reset", 32'({busy, done, spsr_we, psr_we, lr_we, pc_we}), 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !spsr_we && !psr_we && !lr_we && !pc_we,
            "R1 quiet after reset", 32'({busy, done, spsr_we, psr_we, lr_we, pc_we}), 32'h0);
        // Every kind, both states, several addresses
        for (int i = 0; i < 7; i++)
            for (int t = 0; t < 2; t++)
                for (int p = 0; p < 3; p++)
                    for (int s = 0; s < 2; s++)
                        run_entry(7'(1 << i), psrs[s] | (t != 0 ? 32'h20 : 32'h0),
                                  pcs[p], 7'h7F);
        // All request combinations (R3)
        for (int r = 1; r < 128; r++)
            run_entry(7'(r), 32'h1000_003F ^ 32'(r << 8), 32'h0000_0400 + 32'(r * 4), ~7'(r));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule